// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits on the processor side of an interrupt controller. It holds the status register and its shadow copies, and it decides when a pending request is taken. A request is taken only at an instruction boundary. The status register must not block it, and the request level must be above the current mask level. When a request is taken, the block does the whole entry step in one clock. It records the source code and copies status and program counter into shadow registers. It raises the block, privileged-mode and register-bank bits, and it sends fetch to the vector base plus 0x600.

A return input undoes the entry. It reloads status from its shadow and redirects fetch to the saved program counter. A separate status-load input stands for an instruction that writes the status register; software uses it to open the mask and clear the block bit. The priority order between these three events is fixed, so at most one of them acts in any clock.

Top module: `exc_entry_seq`

## Requirements
- R1: A request is taken only in a cycle where the boundary strobe, the request and the not-blocked condition are all high, and the request level is strictly greater than the status mask field (status bits 7:4). An equal or lower level is not taken.
- R2: When a request is taken, the event register holds the source code from the next clock on. The taken flag is high for exactly that one clock, and the redirect address is then the vector base plus 0x600, modulo 2^32.
- R3: When a request is taken, the saved-status register receives the status value from before entry, and the saved-PC register receives the current program counter input.
- R4: On entry the status register's block bit (28), bank bit (29) and privileged-mode bit (30) become 1. Every other status bit, the mask field included, keeps its value.
- R5: While the status block bit is 1, no request is taken, whatever the request, level and boundary inputs are.
- R6: A return loads the status register from the saved-status register and sets the redirect address to the saved PC. The return flag is high for exactly one clock, and the saved-status, saved-PC and event registers keep their values.
- R7: When a return and an otherwise acceptable request arrive in the same clock, only the return acts. The request is judged again at a later boundary, against the restored status.
- R8: A status load writes its value into the status register, unless a return is present in that clock. A status load, like a return, stops any request from being taken in that clock.
- R9: Reset sets status to 0x700000F0, the shadows, the event register and the redirect address to 0, and both flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | 1 | Request from the interrupt controller |
| irq_level_i | input | 4 | Priority level of the request |
| irq_code_i | input | 12 | Source code of the request |
| insn_bnd_i | input | 1 | Instruction boundary strobe |
| pc_i | input | 32 | Current program counter |
| vbr_i | input | 32 | Vector base |
| rte_i | input | 1 | Return from exception |
| sr_ld_i | input | 1 | Status register load |
| sr_ld_val_i | input | 32 | Value for the status load |
| sr_o | output | 32 | Status register |
| ssr_o | output | 32 | Saved status |
| spc_o | output | 32 | Saved program counter |
| evt_o | output | 12 | Event code of the last taken request |
| taken_o | output | 1 | One-clock entry flag |
| ret_o | output | 1 | One-clock return flag |
| redirect_pc_o | output | 32 | New fetch address for entry or return |

## Verification
The hardest case to reach from the ports is a return in the same clock as an eligible request, where the saved status has the block bit clear. The return must win, and a later boundary must take the request against the restored status. The directed phase builds this case: a status load opens the mask, a first entry loads the shadow with an open status, and the second request then arrives with the return. Random stimulus follows, with the boundary, request and return rates weighted so that BL-blocked, equal-level and three-way collisions all come up many times.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int          XLEN      = 32,
  parameter int          CODE_W    = 12,
  parameter int          LVL_W     = 4,
  parameter int          IMASK_LSB = 4,
  parameter int          BL_BIT    = 28,
  parameter int          RB_BIT    = 29,
  parameter int          MD_BIT    = 30,
  parameter logic [31:0] VEC_OFS   = 32'h0000_0600,
  parameter logic [31:0] SR_RST    = 32'h7000_00F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req_i,
  input  logic [LVL_W-1:0]  irq_level_i,
  input  logic [CODE_W-1:0] irq_code_i,
  input  logic              insn_bnd_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic              rte_i,
  input  logic              sr_ld_i,
  input  logic [XLEN-1:0]   sr_ld_val_i,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [CODE_W-1:0] evt_o,
  output logic              taken_o,
  output logic              ret_o,
  output logic [XLEN-1:0]   redirect_pc_o
);

  localparam logic [XLEN-1:0] ENTRY_SET =
    (XLEN'(1) << BL_BIT) | (XLEN'(1) << RB_BIT) | (XLEN'(1) << MD_BIT);

  logic [LVL_W-1:0] imask;
  logic             blocked;
  logic             accept;

  assign imask   = sr_o[IMASK_LSB +: LVL_W];
  assign blocked = sr_o[BL_BIT];
  assign accept  = insn_bnd_i && irq_req_i && !blocked && (irq_level_i > imask)
                   && !rte_i && !sr_ld_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_o          <= SR_RST[XLEN-1:0];
      ssr_o         <= '0;
      spc_o         <= '0;
      evt_o         <= '0;
      taken_o       <= 1'b0;
      ret_o         <= 1'b0;
      redirect_pc_o <= '0;
    end else begin
      taken_o <= accept;
      ret_o   <= rte_i;
      if (rte_i) begin
        sr_o          <= ssr_o;
        redirect_pc_o <= spc_o;
      end else if (sr_ld_i) begin
        sr_o <= sr_ld_val_i;
      end else if (accept) begin
        evt_o         <= irq_code_i;
        ssr_o         <= sr_o;
        spc_o         <= pc_i;
        sr_o          <= sr_o | ENTRY_SET;
        redirect_pc_o <= vbr_i + XLEN'(VEC_OFS);
      end
    end
  end

  assert_bnd_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_bnd_i |=> !taken_o);

  assert_level_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level_i <= sr_o[IMASK_LSB +: LVL_W]) |=> !taken_o);

  assert_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> redirect_pc_o == $past(vbr_i) + XLEN'(VEC_OFS));

  assert_shadow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> (ssr_o == $past(sr_o)) && (spc_o == $past(pc_i)));

  assert_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> sr_o[BL_BIT] && sr_o[RB_BIT] && sr_o[MD_BIT] &&
                (sr_o[IMASK_LSB +: LVL_W] == $past(sr_o[IMASK_LSB +: LVL_W])));

  assert_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sr_o[BL_BIT] |=> !taken_o);

  assert_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rte_i |=> ret_o && (sr_o == $past(ssr_o)) && (redirect_pc_o == $past(spc_o))
              && $stable(ssr_o) && $stable(spc_o) && $stable(evt_o));

  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(taken_o && ret_o));

  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_ld_i && !rte_i) |=> (sr_o == $past(sr_ld_val_i)) && !taken_o);

endmodule

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0;
  logic [3:0]  irq_level = '0;
  logic [11:0] irq_code = '0;
  logic        insn_bnd = 1'b0;
  logic [31:0] pc = '0;
  logic [31:0] vbr = '0;
  logic        rte = 1'b0;
  logic        sr_ld = 1'b0;
  logic [31:0] sr_ld_val = '0;
  logic [31:0] sr, ssr, spc, rpc;
  logic [11:0] evt;
  logic        taken, ret;

  always #2 clk = ~clk;

  exc_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .irq_level_i(irq_level),
    .irq_code_i(irq_code), .insn_bnd_i(insn_bnd), .pc_i(pc), .vbr_i(vbr),
    .rte_i(rte), .sr_ld_i(sr_ld), .sr_ld_val_i(sr_ld_val),
    .sr_o(sr), .ssr_o(ssr), .spc_o(spc), .evt_o(evt),
    .taken_o(taken), .ret_o(ret), .redirect_pc_o(rpc));

  // behavioural reference
  logic [31:0] m_sr, m_ssr, m_spc, m_rpc;
  logic [11:0] m_evt;
  logic        m_taken, m_ret;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int n_taken = 0;
  int n_ret   = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sr = 32'h7000_00F0; m_ssr = 0; m_spc = 0; m_rpc = 0; m_evt = 0;
      m_taken = 0; m_ret = 0;
    end else begin
      m_taken = 0; m_ret = 0;
      if (rte) begin
        m_sr = m_ssr; m_rpc = m_spc; m_ret = 1;
      end else if (sr_ld) begin
        m_sr = sr_ld_val;
      end else if (insn_bnd && irq_req && !m_sr[28] && (irq_level > m_sr[7:4])) begin
        m_evt = irq_code; m_ssr = m_sr; m_spc = pc;
        m_sr = m_sr | 32'h7000_0000; m_rpc = vbr + 32'h600; m_taken = 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R4/R8 status", sr, m_sr);
    chk("R3 saved status", ssr, m_ssr);
    chk("R3 saved pc", spc, m_spc);
    chk("R2 event code", {20'h0, evt}, {20'h0, m_evt});
    chk("R1/R5/R7 taken", {31'h0, taken}, {31'h0, m_taken});
    chk("R6 return", {31'h0, ret}, {31'h0, m_ret});
    chk("R2/R6 redirect", rpc, m_rpc);
    if (taken) n_taken++;
    if (ret) n_ret++;
  endtask

  task automatic idle();
    irq_req = 0; insn_bnd = 0; rte = 0; sr_ld = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset values
    chk("R9 reset status", sr, 32'h7000_00F0);
    chk("R9 reset saved", ssr | spc | rpc, 32'h0);
    chk("R9 reset flags", {30'h0, taken, ret}, 32'h0);
    rst_n = 1;
    @(negedge clk); compare_all();

    // R5: blocked by reset status even with high level
    vbr = 32'h8C00_0000; pc = 32'h1000; irq_req = 1; irq_level = 4'hF;
    irq_code = 12'h3A0; insn_bnd = 1;
    step(); idle();
    chk("R5 blocked at reset", {31'h0, taken}, 32'h0);

    // R8: open the status: mask 5, BL clear
    sr_ld = 1; sr_ld_val = 32'h0000_0050; irq_req = 1; insn_bnd = 1; irq_level = 4'hF;
    step(); idle();
    chk("R8 load suppresses accept", {31'h0, taken}, 32'h0);

    // R1: equal level not taken, no boundary not taken
    irq_req = 1; irq_level = 4'h5; insn_bnd = 1; step(); idle();
    chk("R1 equal level", {31'h0, taken}, 32'h0);
    irq_req = 1; irq_level = 4'h9; insn_bnd = 0; step(); idle();
    chk("R1 no boundary", {31'h0, taken}, 32'h0);

    // R2/R3/R4: entry
    pc = 32'h0000_2468; irq_req = 1; irq_level = 4'h6; irq_code = 12'h240; insn_bnd = 1;
    step(); idle();
    chk("R2 taken", {31'h0, taken}, 32'h1);
    chk("R2 vector", rpc, 32'h8C00_0600);
    chk("R4 status bits", sr, 32'h7000_0050);
    chk("R3 saved pc", spc, 32'h0000_2468);
    step();
    chk("R2 one-cycle pulse", {31'h0, taken}, 32'h0);

    // R7: return with an acceptable request; BL in saved status is clear
    rte = 1; irq_req = 1; irq_level = 4'hA; irq_code = 12'h5C0; insn_bnd = 1; pc = 32'h3000;
    step(); idle();
    chk("R7 return wins", {30'h0, taken, ret}, 32'h1);
    chk("R6 status restored", sr, 32'h0000_0050);
    chk("R6 redirect to saved pc", rpc, 32'h0000_2468);
    irq_req = 1; irq_level = 4'hA; irq_code = 12'h5C0; insn_bnd = 1;
    step(); idle();
    chk("R7 re-evaluated", {31'h0, taken}, 32'h1);
    chk("R7 new code", {20'h0, evt}, 32'h0000_05C0);
    chk("R3 saved pc second", spc, 32'h3000);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      irq_req   = ($urandom_range(0, 3) != 0);
      irq_level = 4'($urandom);
      irq_code  = 12'($urandom) & 12'hFE0;
      insn_bnd  = ($urandom_range(0, 2) != 0);
      pc        = $urandom & 32'hFFFF_FFFE;
      vbr       = $urandom;
      rte       = ($urandom_range(0, 9) == 0);
      sr_ld     = ($urandom_range(0, 11) == 0);
      sr_ld_val = {1'b0, 3'($urandom_range(0, 7)) & {1'b1, 1'b1, ($urandom_range(0,1) == 1)},
                   20'($urandom), 4'($urandom), 4'($urandom)};
      step();
    end
    idle(); step();
    checks++;
    if (n_taken == 0 || n_ret == 0) begin
      fails++;
      $display("FAIL R1/R6 coverage: actual taken %0d ret %0d expected nonzero", n_taken, n_ret);
    end
    finish_run();
  end

endmodule